// File: doc/BRIEF.md
# Two-Player Rhythm Game Link Controller

This block sits on the game board of a two-player rhythm game and exchanges bytes with a host PC. The host draws falling tiles and the board reads the players' keypads. A byte serializer outside the block carries the traffic. Received bytes arrive as a one-cycle strobe with data. Outgoing bytes leave through a valid/ready handshake.

The host asks for a hand's note sequence with a single ASCII letter. The block then streams that hand's sequence from an internal constant table. Each note is an uppercase letter that names a keypad key, followed by a duration digit, and a newline closes the table. The host also sends one byte per judged note, telling the block which player hit correctly. The block keeps both scores for the seven-segment drivers and forwards keypad presses to the host.

Each time the host spawns a tile, a free-running 8-bit LFSR steps and its two low bits select one of four rails. When a player's score reaches 60, the match ends. The block sends a close byte, lights that player's winner lamp and ignores every input until reset.

Top module: `rhythm_link_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, both scores are 0, `tx_valid` is 0, both winner lamps are off and `rail` equals the two low bits of the seed 0xB7 (value 3).
- R2: A received 0x52 ('R') outside a stream makes the block transmit the bytes "A2C1B3D2A4" followed by 0x0A, in that order.
- R3: A received 0x72 ('r') outside a stream makes the block transmit "D1B2C2A3" followed by 0x0A, in that order.
- R4: A request byte that arrives while a note sequence is still being transmitted is dropped. No extra sequence follows.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value. A byte counts as sent only on a cycle with both high.
- R6: `rail` is bits [1:0] of an 8-bit LFSR. On each cycle with `tile_spawn` high, the LFSR shifts left and takes as its new bit 0 the XOR of bits 7, 5, 4 and 3 (polynomial x^8+x^6+x^5+x^4+1). At all other times it holds.
- R7: A left key press with digit d sends byte {4'h3,d}, and a right key press sends {4'h4,d}. Each player has one pending slot, and a press that arrives while that player's slot is full is dropped. When several sources are ready, the byte order is: close byte first, then the running note stream, then the left key, then the right key.
- R8: A received 0x4C ('L') raises the left score by 1 and a received 0x48 ('H') raises the right score by 1. Any other non-request byte leaves both scores unchanged.
- R9: When a score reaches 60, that player's winner lamp turns on and stays on. The score stays at 60, and the byte 0x58 ('X') is transmitted exactly once, ahead of any other pending byte.
- R10: After the game ends, received bytes, key presses and tile spawns have no effect. Scores, rail and the transmitted stream stay unchanged, and any unsent stream or key bytes are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on rx_data |
| rx_data | input | 8 | Received byte |
| key_l_valid | input | 1 | Left keypad press strobe |
| key_l_digit | input | 4 | Left keypad digit |
| key_r_valid | input | 1 | Right keypad press strobe |
| key_r_digit | input | 4 | Right keypad digit |
| tile_spawn | input | 1 | Host spawned a tile; step the rail generator |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Serializer accepts the byte this cycle |
| rail | output | 2 | Rail code for the newest tile |
| score_l | output | 7 | Left player score |
| score_r | output | 7 | Right player score |
| win_l | output | 1 | Left player won |
| win_r | output | 1 | Right player won |

## Verification
Several properties are checked on every clock cycle:
- a held byte does not change under backpressure;
- scores never pass 60 and only step by one;
- at most one winner lamp is lit, and a lit lamp stays lit;
- the LFSR never locks at zero.

Other behaviour only shows up over whole scenarios: the exact byte order of each note table, dropped requests and key presses, the priority between close, stream and key bytes, and the silence after game end. The bench's per-cycle reference model, together with captured-byte comparisons, covers these.

// File: rtl/rhythm_link_ctrl.sv
module rhythm_link_ctrl #(
  parameter int          WIN_SCORE = 60,
  parameter int          SCORE_W   = 7,
  parameter logic [7:0]  LFSR_SEED = 8'hB7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  input  logic [7:0]         rx_data,
  input  logic               key_l_valid,
  input  logic [3:0]         key_l_digit,
  input  logic               key_r_valid,
  input  logic [3:0]         key_r_digit,
  input  logic               tile_spawn,
  output logic               tx_valid,
  output logic [7:0]         tx_data,
  input  logic               tx_ready,
  output logic [1:0]         rail,
  output logic [SCORE_W-1:0] score_l,
  output logic [SCORE_W-1:0] score_r,
  output logic               win_l,
  output logic               win_r
);
  localparam logic [7:0] REQ_LEFT  = 8'h52;
  localparam logic [7:0] REQ_RIGHT = 8'h72;
  localparam logic [7:0] HIT_LEFT  = 8'h4C;
  localparam logic [7:0] HIT_RIGHT = 8'h48;
  localparam logic [7:0] CLOSE_B   = 8'h58;
  localparam logic [7:0] TERM_B    = 8'h0A;
  localparam int LEFT_LEN  = 11;
  localparam int RIGHT_LEN = 9;
  localparam logic [8*LEFT_LEN-1:0]  LEFT_TAB  = "A2C1B3D2A4\n";
  localparam logic [8*RIGHT_LEN-1:0] RIGHT_TAB = "D1B2C2A3\n";
  localparam logic [SCORE_W-1:0] LAST_PT = SCORE_W'(WIN_SCORE - 1);
  localparam logic [SCORE_W-1:0] TOP_PT  = SCORE_W'(WIN_SCORE);

  logic       streaming, side_r, pend_l, pend_r, close_pend, over;
  logic [3:0] idx, dig_l, dig_r;
  logic [7:0] lfsr, cur_note;

  wire tx_free = !tx_valid || tx_ready;
  wire is_req  = rx_valid && (rx_data == REQ_LEFT || rx_data == REQ_RIGHT);
  wire hit_l   = rx_valid && rx_data == HIT_LEFT;
  wire hit_r   = rx_valid && rx_data == HIT_RIGHT;
  wire finish  = (hit_l && score_l == LAST_PT) || (hit_r && score_r == LAST_PT);
  wire [7:0] lfsr_next = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  assign rail = lfsr[1:0];

  always_comb begin
    if (side_r) cur_note = (int'(idx) < RIGHT_LEN) ? RIGHT_TAB[8*(RIGHT_LEN-1-int'(idx)) +: 8] : TERM_B;
    else        cur_note = (int'(idx) < LEFT_LEN)  ? LEFT_TAB[8*(LEFT_LEN-1-int'(idx)) +: 8]   : TERM_B;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0; tx_data <= 8'h00;
      streaming <= 1'b0; side_r <= 1'b0; idx <= '0;
      pend_l <= 1'b0; pend_r <= 1'b0; dig_l <= '0; dig_r <= '0;
      close_pend <= 1'b0; over <= 1'b0;
      score_l <= '0; score_r <= '0; win_l <= 1'b0; win_r <= 1'b0;
      lfsr <= LFSR_SEED;
    end else begin
      if (tx_free) begin
        if (close_pend) begin
          tx_valid <= 1'b1; tx_data <= CLOSE_B; close_pend <= 1'b0;
        end else if (streaming) begin
          tx_valid <= 1'b1; tx_data <= cur_note; idx <= idx + 4'd1;
          if (cur_note == TERM_B) streaming <= 1'b0;
        end else if (pend_l) begin
          tx_valid <= 1'b1; tx_data <= {4'h3, dig_l}; pend_l <= 1'b0;
        end else if (pend_r) begin
          tx_valid <= 1'b1; tx_data <= {4'h4, dig_r}; pend_r <= 1'b0;
        end else begin
          tx_valid <= 1'b0;
        end
      end
      if (!over) begin
        if (is_req && !streaming) begin
          streaming <= 1'b1; side_r <= (rx_data == REQ_RIGHT); idx <= '0;
        end
        if (hit_l) score_l <= score_l + 1'b1;
        if (hit_r) score_r <= score_r + 1'b1;
        if (key_l_valid && !pend_l) begin pend_l <= 1'b1; dig_l <= key_l_digit; end
        if (key_r_valid && !pend_r) begin pend_r <= 1'b1; dig_r <= key_r_digit; end
        if (tile_spawn) lfsr <= lfsr_next;
        if (finish) begin
          over <= 1'b1; close_pend <= 1'b1;
          win_l <= hit_l; win_r <= hit_r;
          streaming <= 1'b0; pend_l <= 1'b0; pend_r <= 1'b0;
        end
      end
    end
  end

  p_hold_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  p_score_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    score_l <= TOP_PT && score_r <= TOP_PT);

  p_score_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (score_l == $past(score_l) || score_l == $past(score_l) + 1'b1) &&
             (score_r == $past(score_r) || score_r == $past(score_r) + 1'b1));

  p_one_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({win_l, win_r}));

  p_win_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (win_l || win_r) |=> $stable({win_l, win_r, score_l, score_r, rail}));

  p_lfsr_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 8'h00);

  p_rail_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tile_spawn |=> $stable(rail));
endmodule

// File: tb/sim_rhythm_link_ctrl.sv
module sim_rhythm_link_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, key_l_valid = 1'b0, key_r_valid = 1'b0, tile_spawn = 1'b0, tx_ready = 1'b1;
  logic [7:0] rx_data = 8'h00;
  logic [3:0] key_l_digit = 4'h0, key_r_digit = 4'h0;
  logic tx_valid, win_l, win_r;
  logic [7:0] tx_data;
  logic [1:0] rail;
  logic [6:0] score_l, score_r;

  always #5 clk = ~clk;

  rhythm_link_ctrl u0 (.clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .key_l_valid(key_l_valid), .key_l_digit(key_l_digit), .key_r_valid(key_r_valid),
    .key_r_digit(key_r_digit), .tile_spawn(tile_spawn), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rail(rail), .score_l(score_l), .score_r(score_r), .win_l(win_l), .win_r(win_r));

  int checks = 0, fails = 0;
  string tab_l = "A2C1B3D2A4\n";
  string tab_r = "D1B2C2A3\n";
  byte unsigned got[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_sl, m_sr, m_lfsr, m_idx, m_dl, m_dr, m_txd;
  bit m_over, m_wl, m_wr, m_txv, m_act, m_side, m_pl, m_pr, m_close;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sl = 0; m_sr = 0; m_lfsr = 8'hB7; m_idx = 0; m_dl = 0; m_dr = 0; m_txd = 0;
      m_over = 0; m_wl = 0; m_wr = 0; m_txv = 0; m_act = 0; m_side = 0;
      m_pl = 0; m_pr = 0; m_close = 0;
    end else begin
      automatic bit o_act = m_act, o_pl = m_pl, o_pr = m_pr, o_close = m_close, o_over = m_over;
      automatic int o_sl = m_sl, o_sr = m_sr;
      automatic int b;
      if (tx_valid && tx_ready) got.push_back(tx_data);
      if (!m_txv || tx_ready) begin
        if (o_close) begin m_txv = 1; m_txd = 8'h58; m_close = 0; end
        else if (o_act) begin
          b = m_side ? tab_r[m_idx] : tab_l[m_idx];
          m_txv = 1; m_txd = b; m_idx++;
          if (b == 10) m_act = 0;
        end
        else if (o_pl) begin m_txv = 1; m_txd = 8'h30 + m_dl; m_pl = 0; end
        else if (o_pr) begin m_txv = 1; m_txd = 8'h40 + m_dr; m_pr = 0; end
        else m_txv = 0;
      end
      if (!o_over) begin
        if (rx_valid && (rx_data == 8'h52 || rx_data == 8'h72) && !o_act) begin
          m_act = 1; m_side = (rx_data == 8'h72); m_idx = 0;
        end
        if (rx_valid && rx_data == 8'h4C) m_sl = o_sl + 1;
        if (rx_valid && rx_data == 8'h48) m_sr = o_sr + 1;
        if (key_l_valid && !o_pl) begin m_pl = 1; m_dl = key_l_digit; end
        if (key_r_valid && !o_pr) begin m_pr = 1; m_dr = key_r_digit; end
        if (tile_spawn)
          m_lfsr = ((m_lfsr << 1) | (((m_lfsr >> 7) ^ (m_lfsr >> 5) ^ (m_lfsr >> 4) ^ (m_lfsr >> 3)) & 1)) & 255;
        if (m_sl == 60 || m_sr == 60) begin
          m_over = 1; m_close = 1; m_wl = (m_sl == 60); m_wr = (m_sr == 60);
          m_act = 0; m_pl = 0; m_pr = 0;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(tx_valid == m_txv, "R5", "tx_valid", tx_valid, m_txv);
    if (m_txv) chk(tx_data == m_txd[7:0], "R7", "tx_data", tx_data, m_txd);
    chk(rail == m_lfsr[1:0], "R6", "rail", rail, m_lfsr & 3);
    chk(score_l == m_sl && score_r == m_sr, "R8", "scores", score_l * 100 + score_r, m_sl * 100 + m_sr);
    chk(win_l == m_wl && win_r == m_wr, "R9", "winner", {win_l, win_r}, {m_wl, m_wr});
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input byte unsigned b);
    rx_valid = 1; rx_data = b; tick(); rx_valid = 0;
  endtask

  task automatic expect_str(input string s, input string req);
    chk(got.size() == s.len(), req, "byte count", got.size(), s.len());
    for (int i = 0; i < s.len() && i < got.size(); i++)
      chk(got[i] == s[i], req, "stream byte", got[i], s[i]);
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(3);
    chk(score_l == 0 && score_r == 0, "R1", "reset scores", score_l + score_r, 0);
    chk(tx_valid == 0, "R1", "reset tx_valid", tx_valid, 0);
    chk(rail == 2'd3, "R1", "reset rail", rail, 3);
    chk(!win_l && !win_r, "R1", "reset lamps", {win_l, win_r}, 0);
    rst_n = 1; tick(2);

    for (int i = 0; i < 6; i++) begin tile_spawn = 1; tick(); tile_spawn = 0; tick(); end

    got.delete(); send(8'h52); tick(3); send(8'h72); send(8'h52); tick(20);
    expect_str(tab_l, "R2");   // R4: requests during stream add nothing

    got.delete(); send(8'h72);
    for (int i = 0; i < 45; i++) begin tx_ready = (i % 3 != 0); tick(); end
    tx_ready = 1; tick(3);
    expect_str(tab_r, "R3");   // with backpressure, R5

    got.delete();
    key_l_valid = 1; key_l_digit = 5; key_r_valid = 1; key_r_digit = 9; tick();
    key_r_valid = 0; key_l_digit = 6; tick(); key_l_valid = 0; tick(4);
    chk(got.size() == 2, "R7", "key byte count", got.size(), 2);
    if (got.size() == 2) begin
      chk(got[0] == 8'h35, "R7", "left key byte", got[0], 8'h35);
      chk(got[1] == 8'h49, "R7", "right key byte", got[1], 8'h49);
    end

    got.delete(); send(8'h52); key_l_valid = 1; key_l_digit = 2; tick(); key_l_valid = 0; tick(20);
    chk(got.size() == 12, "R7", "stream+key count", got.size(), 12);
    if (got.size() == 12) chk(got[11] == 8'h32, "R7", "key after stream", got[11], 8'h32);

    send(8'h4C); send(8'h4C); send(8'h4C); send(8'h48); send(8'h48); send(8'h5A); send(8'h68);
    tick();
    chk(score_l == 3 && score_r == 2, "R8", "scores after feedback", score_l * 100 + score_r, 302);

    got.delete(); tx_ready = 0; send(8'h72); key_r_valid = 1; key_r_digit = 1; tick(); key_r_valid = 0;
    for (int i = 0; i < 57; i++) send(8'h4C);
    tick(); tx_ready = 1; tick(6);
    chk(score_l == 60 && win_l && !win_r, "R9", "left wins", score_l, 60);
    begin
      automatic int nx = 0;
      foreach (got[i]) if (got[i] == 8'h58) nx++;
      chk(nx == 1, "R9", "close byte count", nx, 1);
      chk(got.size() == 2 && got[got.size()-1] == 8'h58, "R9", "close follows held byte",
          got.size(), 2);
    end

    begin
      automatic logic [1:0] r0 = rail;
      got.delete();
      send(8'h48); send(8'h52); send(8'h4C);
      key_l_valid = 1; tile_spawn = 1; tick(); key_l_valid = 0; tile_spawn = 0; tick(10);
      chk(score_r == 2 && score_l == 60, "R10", "scores frozen", score_r, 2);
      chk(rail == r0, "R10", "rail frozen", rail, r0);
      chk(got.size() == 0, "R10", "no bytes after end", got.size(), 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule